// File: doc/BRIEF.md
# Selectable-Feedback Shift Sequence Generator

This block is a parameterised shift register of WIDTH stages, from 3 to 16. Its feedback into stage 0 can be switched among three schemes, chosen by a two-bit mode input:

- **Circulating single-token ring.** The last stage is copied back into stage 0 unchanged.
- **Twisted ring.** The last stage is inverted before it is fed back.
- **Maximal-length linear feedback.** Stage 0 receives the XOR of a fixed set of tap stages. The taps are taken from an internal table of primitive polynomials, one for each supported width.

Each scheme gives a different cycle length: WIDTH, 2·WIDTH and 2^WIDTH − 1 states. The block serves as a state-sequence source for decoders and sequencers, or as a pseudo-random bit source.

Every shift moves the register one stage toward the MSB, and the new bit enters stage 0. The serial output is the MSB. A synchronous active-low reset places the register at a home value that depends on the current mode. A load strobe seeds it with any value, and a seed that would lock the ring or the linear-feedback scheme is replaced. The mode can change at any time. The current contents are kept, and the next shift uses the new feedback.

Top module: `shift_seq_gen`

## Requirements
- R1: With rst_n low at a rising clock edge, state becomes 0 in mode 1 (twisted ring) and becomes 1 (only bit 0 set) in modes 0, 2 and 3.
- R2: With rst_n high, load low and shift_en low, state keeps its value across the edge.
- R3: In mode 0 (ring), a shift moves state[i] into state[i+1] and the old MSB into bit 0. From the home value 1, the state first returns to 1 after exactly WIDTH shifts.
- R4: In mode 1 (twisted ring), a shift moves state[i] into state[i+1] and the inverted old MSB into bit 0. From 0, the state first returns to 0 after exactly 2·WIDTH shifts.
- R5: In modes 2 and 3 (linear feedback), bit 0 receives the XOR of the tap stages, which are bits 7,5,4,3 for WIDTH 8 and bits 2,1 for WIDTH 3. From 1, the state visits 2^WIDTH − 1 distinct nonzero values before it first returns to 1.
- R6: With rst_n high, load high overrides shift_en and state takes seed. In modes 0, 2 and 3 a zero seed gives 1 instead. In mode 1 a zero seed gives 0.
- R7: serial_out always equals the MSB of state.
- R8: In modes 0, 2 and 3, a shift from the all-zero state produces 1, so neither the ring nor the linear-feedback scheme stays locked at zero.
- R9: A change of mode leaves state unchanged. The next shift uses the feedback of the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset to the mode's home value |
| load | input | 1 | Seed load strobe, above shift in priority |
| seed | input | WIDTH | Value loaded when load is high |
| mode | input | 2 | 0 ring, 1 twisted ring, 2 or 3 linear feedback |
| shift_en | input | 1 | Advance the sequence by one step |
| state | output | WIDTH | Parallel register contents |
| serial_out | output | 1 | MSB of the register |

## Verification
The bench builds two instances side by side, one with WIDTH 8 and one with WIDTH 3, and drives both with the same stimulus. WIDTH 3 is the smallest legal width. It makes the full linear-feedback cycle of 7 states short enough that every random mode switch and reload lands in a well-explored state space. WIDTH 8 brings the full 255-state period within reach, so the bench can scan it completely for repeats and zero states. It also exercises a four-tap feedback term rather than a two-tap one.

// File: rtl/ssg_pkg.sv
// Package: shared mode encoding, tap table and home values for the
// shift sequence generator. Assumes widths between 3 and 16.
package ssg_pkg;

    typedef enum logic [1:0] {
        MODE_RING   = 2'd0,
        MODE_TWIST  = 2'd1,
        MODE_LFSR   = 2'd2,
        MODE_LFSR_B = 2'd3
    } ssg_mode_e;

    localparam int unsigned SSG_MAX_W = 16;

    // Tap mask of a maximal-length Fibonacci register; bit k marks stage k.
    function automatic logic [SSG_MAX_W-1:0] ssg_taps(input int unsigned n);
        logic [SSG_MAX_W-1:0] m;
        case (n)
            3:       m = 16'h0006;
            4:       m = 16'h000C;
            5:       m = 16'h0014;
            6:       m = 16'h0030;
            7:       m = 16'h0060;
            8:       m = 16'h00B8;
            9:       m = 16'h0110;
            10:      m = 16'h0240;
            11:      m = 16'h0500;
            12:      m = 16'h0829;
            13:      m = 16'h100D;
            14:      m = 16'h2015;
            15:      m = 16'h6000;
            16:      m = 16'hD008;
            default: m = 16'h0000;
        endcase
        return m;
    endfunction

    // True when the mode cannot tolerate an all-zero register.
    function automatic logic ssg_needs_token(input logic [1:0] md);
        return (md != MODE_TWIST);
    endfunction

endpackage

// File: rtl/ssg_feedback.sv
// Module: ssg_feedback
// Computes the bit that enters stage 0 on a shift, for the selected mode.
// Assumes WIDTH in 3..16 so that the package tap table has an entry.
// Ring and linear-feedback modes inject a 1 when the register is all zero.
module ssg_feedback
    import ssg_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [1:0]       mode,
    output logic             fb_bit,
    output logic             is_zero
);

    localparam logic [SSG_MAX_W-1:0] TAPS_FULL = ssg_taps(WIDTH);
    localparam logic [WIDTH-1:0]     TAPS      = TAPS_FULL[WIDTH-1:0];
    localparam int unsigned          MSB       = WIDTH - 1;

    logic [WIDTH-1:0] tapped;

    // One masking gate per stage; untapped stages tie off to zero.
    for (genvar i = 0; i < WIDTH; i++) begin : g_tap
        if (TAPS[i]) begin : g_on
            assign tapped[i] = cur[i];
        end else begin : g_off
            assign tapped[i] = 1'b0;
        end
    end

    // Zero detector shared by the lockup guard and the seed filter.
    assign is_zero = (cur == '0);

    // Select the feedback term from the mode.
    always_comb begin
        case (ssg_mode_e'(mode))
            MODE_RING:  fb_bit = cur[MSB] | is_zero;
            MODE_TWIST: fb_bit = ~cur[MSB];
            default:    fb_bit = (^tapped) | is_zero;
        endcase
    end

endmodule

// File: rtl/ssg_next_sel.sv
// Module: ssg_next_sel
// Chooses the next register value by priority: reset, load, shift, hold.
// Assumes rst_n is synchronous; zero seeds are replaced where they would lock.
module ssg_next_sel
    import ssg_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] seed,
    input  logic [1:0]       mode,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift_en,
    input  logic             fb_bit,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] TOKEN = WIDTH'(1);

    logic             token_mode;
    logic [WIDTH-1:0] home_val;
    logic [WIDTH-1:0] seed_val;

    // Home value and seed filter depend only on the mode.
    always_comb begin
        token_mode = ssg_needs_token(mode);
        home_val   = token_mode ? TOKEN : '0;
        seed_val   = (token_mode && (seed == '0)) ? TOKEN : seed;
    end

    // Priority selection of the next state.
    always_comb begin
        if (!rst_n) begin
            nxt = home_val;
        end else if (load) begin
            nxt = seed_val;
        end else if (shift_en) begin
            nxt = {cur[WIDTH-2:0], fb_bit};
        end else begin
            nxt = cur;
        end
    end

endmodule

// File: rtl/ssg_stage_reg.sv
// Module: ssg_stage_reg
// The storage stages. All control is folded into nxt, so this is a plain
// edge-triggered register; its contents are unknown until the first reset edge.
module ssg_stage_reg #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] q
);

    // Capture the next state on every rising edge.
    always_ff @(posedge clk) begin
        q <= nxt;
    end

endmodule

// File: rtl/shift_seq_gen.sv
// Module: shift_seq_gen
// Shift register with ring, twisted-ring or maximal-length linear feedback.
// Assumes 3 <= WIDTH <= 16. Shifts toward the MSB; serial_out is the MSB.
module shift_seq_gen #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] seed,
    input  logic [1:0]       mode,
    input  logic             shift_en,
    output logic [WIDTH-1:0] state,
    output logic             serial_out
);

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_nxt;
    logic             fb_bit;
    logic             is_zero;

    ssg_feedback #(.WIDTH(WIDTH)) u_fb (
        .cur     (state_q),
        .mode    (mode),
        .fb_bit  (fb_bit),
        .is_zero (is_zero)
    );

    ssg_next_sel #(.WIDTH(WIDTH)) u_sel (
        .cur      (state_q),
        .seed     (seed),
        .mode     (mode),
        .rst_n    (rst_n),
        .load     (load),
        .shift_en (shift_en),
        .fb_bit   (fb_bit),
        .nxt      (state_nxt)
    );

    ssg_stage_reg #(.WIDTH(WIDTH)) u_reg (
        .clk (clk),
        .nxt (state_nxt),
        .q   (state_q)
    );

    // Drive the outputs from the register.
    assign state      = state_q;
    assign serial_out = state_q[WIDTH-1];

    logic unused_zero;
    assign unused_zero = is_zero;

endmodule

// File: rtl/ssg_checker.sv
// Module: ssg_checker
// Temporal properties of shift_seq_gen, attached by bind below.
module ssg_checker #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic [WIDTH-1:0] seed,
    input logic [1:0]       mode,
    input logic             shift_en,
    input logic [WIDTH-1:0] state
);

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift_en) |=> $stable(state));

    // R3
    ring_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && shift_en && !load && state != '0)
        |=> (state == {$past(state[WIDTH-2:0]), $past(state[WIDTH-1])}));

    // R4
    twist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && shift_en && !load)
        |=> (state == {$past(state[WIDTH-2:0]), ~$past(state[WIDTH-1])}));

    // R5
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && shift_en && !load) |=> (state != '0));

    // R6
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && seed != '0) |=> (state == $past(seed)));

    // R8
    ring_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && shift_en && !load && state == '0) |=> (state == WIDTH'(1)));

endmodule

bind shift_seq_gen ssg_checker #(.WIDTH(WIDTH)) u_ssg_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .seed     (seed),
    .mode     (mode),
    .shift_en (shift_en),
    .state    (state)
);

// File: tb/shift_seq_gen_bench.sv
module shift_seq_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic        shift_en = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [15:0] seed = 16'h0;

    logic [7:0] st8;
    logic       so8;
    logic [2:0] st3;
    logic       so3;

    int   checks = 0;
    int   failures = 0;
    logic [15:0] exp8 = 16'h0;
    logic [15:0] exp3 = 16'h0;

    always #5 clk = ~clk;

    shift_seq_gen #(.WIDTH(8)) u_shift_seq_gen (
        .clk(clk), .rst_n(rst_n), .load(load), .seed(seed[7:0]), .mode(mode),
        .shift_en(shift_en), .state(st8), .serial_out(so8)
    );

    shift_seq_gen #(.WIDTH(3)) u_shift_seq_gen_w3 (
        .clk(clk), .rst_n(rst_n), .load(load), .seed(seed[2:0]), .mode(mode),
        .shift_en(shift_en), .state(st3), .serial_out(so3)
    );

    function automatic logic [15:0] taps_of(input int w);
        return (w == 8) ? 16'h00B8 : 16'h0006;
    endfunction

    // Reference next-state model written from the requirements.
    function automatic logic [15:0] model_next(input int w, input logic [1:0] md,
            input logic [15:0] s, input logic rn, input logic ld,
            input logic [15:0] sd, input logic en);
        logic [15:0] mask;
        logic        fb;
        mask = (16'h1 << w) - 16'h1;
        if (!rn) return (md == 2'd1) ? 16'h0 : 16'h1;
        if (ld) begin
            if ((sd & mask) == 16'h0 && md != 2'd1) return 16'h1;
            return sd & mask;
        end
        if (!en) return s;
        if (md == 2'd0)      fb = s[w-1] | (s == 16'h0);
        else if (md == 2'd1) fb = ~s[w-1];
        else                 fb = (^(s & taps_of(w))) | (s == 16'h0);
        return ((s << 1) | {15'h0, fb}) & mask;
    endfunction

    function automatic string tag_of(input logic rn, input logic ld,
            input logic en, input logic [1:0] md);
        if (!rn) return "R1";
        if (ld)  return "R6";
        if (!en) return "R2";
        if (md == 2'd0) return "R3";
        if (md == 2'd1) return "R4";
        return "R5";
    endfunction

    task automatic check(input logic ok, input string tag,
            input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // One clock: drive at negedge, compare both widths at the following negedge.
    task automatic step(input logic rn, input logic ld, input logic en,
            input logic [1:0] md, input logic [15:0] sd);
        logic [15:0] e8;
        logic [15:0] e3;
        string       t;
        rst_n = rn; load = ld; shift_en = en; mode = md; seed = sd;
        e8 = model_next(8, md, exp8, rn, ld, sd, en);
        e3 = model_next(3, md, exp3, rn, ld, sd, en);
        t  = tag_of(rn, ld, en, md);
        @(posedge clk);
        @(negedge clk);
        exp8 = e8;
        exp3 = e3;
        check(st8 == e8[7:0], t, {8'h0, st8}, e8);
        check(st3 == e3[2:0], t, {13'h0, st3}, e3);
        check(so8 == e8[7] && so3 == e3[2], "R7", {14'h0, so8, so3}, {14'h0, e8[7], e3[2]});
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(10 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int unsigned dummy;
        int ret8;
        int ret3;
        logic [255:0] seen8;
        logic dup8;
        logic zero8;
        dummy = $urandom(32'd20240611);
        @(negedge clk);

        // R1: home values per mode
        step(1'b0, 1'b0, 1'b0, 2'd1, 16'h0);
        check(st8 == 8'h00 && st3 == 3'h0, "R1 twist home", {8'h0, st8}, 16'h0);
        step(1'b0, 1'b0, 1'b1, 2'd2, 16'h0);
        check(st8 == 8'h01 && st3 == 3'h1, "R1 lfsr home", {8'h0, st8}, 16'h1);
        step(1'b0, 1'b0, 1'b0, 2'd0, 16'h0);
        check(st8 == 8'h01 && st3 == 3'h1, "R1 ring home", {8'h0, st8}, 16'h1);

        // R3: ring period equals WIDTH
        ret8 = 0; ret3 = 0;
        for (int i = 1; i <= 16; i++) begin
            step(1'b1, 1'b0, 1'b1, 2'd0, 16'h0);
            if (ret8 == 0 && st8 == 8'h01) ret8 = i;
            if (ret3 == 0 && st3 == 3'h1) ret3 = i;
        end
        check(ret8 == 8, "R3 ring period w8", 16'(ret8), 16'd8);
        check(ret3 == 3, "R3 ring period w3", 16'(ret3), 16'd3);

        // R4: twisted ring period equals 2*WIDTH
        step(1'b0, 1'b0, 1'b0, 2'd1, 16'h0);
        ret8 = 0; ret3 = 0;
        for (int i = 1; i <= 20; i++) begin
            step(1'b1, 1'b0, 1'b1, 2'd1, 16'h0);
            if (ret8 == 0 && st8 == 8'h00) ret8 = i;
            if (ret3 == 0 && st3 == 3'h0) ret3 = i;
        end
        check(ret8 == 16, "R4 twist period w8", 16'(ret8), 16'd16);
        check(ret3 == 6, "R4 twist period w3", 16'(ret3), 16'd6);

        // R5: full linear-feedback period, no repeats, never zero
        step(1'b0, 1'b0, 1'b0, 2'd2, 16'h0);
        seen8 = '0; seen8[1] = 1'b1; dup8 = 1'b0; zero8 = 1'b0;
        ret3 = 0;
        for (int i = 1; i <= 255; i++) begin
            step(1'b1, 1'b0, 1'b1, 2'd2, 16'h0);
            if (st8 == 8'h00) zero8 = 1'b1;
            if (i < 255) begin
                if (seen8[st8]) dup8 = 1'b1;
                seen8[st8] = 1'b1;
            end
            if (ret3 == 0 && st3 == 3'h1) ret3 = i;
        end
        check(!dup8, "R5 no repeat within period w8", {15'h0, dup8}, 16'h0);
        check(!zero8, "R5 zero never visited w8", {15'h0, zero8}, 16'h0);
        check(st8 == 8'h01, "R5 period 255 w8", {8'h0, st8}, 16'h1);
        check(ret3 == 7, "R5 period 7 w3", 16'(ret3), 16'd7);

        // R2: hold while shift_en low
        step(1'b1, 1'b0, 1'b1, 2'd3, 16'h0);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 2'(i), 16'h0);
        check(st8 == exp8[7:0], "R2 hold across mode values", {8'h0, st8}, exp8);

        // R6: load priority and zero-seed handling
        step(1'b1, 1'b1, 1'b1, 2'd0, 16'h00A5);
        check(st8 == 8'hA5 && st3 == 3'h5, "R6 load over shift", {8'h0, st8}, 16'hA5);
        step(1'b1, 1'b1, 1'b0, 2'd2, 16'h0000);
        check(st8 == 8'h01, "R6 zero seed lfsr", {8'h0, st8}, 16'h1);
        step(1'b1, 1'b1, 1'b0, 2'd1, 16'h0000);
        check(st8 == 8'h00, "R6 zero seed twist", {8'h0, st8}, 16'h0);

        // R8, R9: leave zero after a mode switch
        step(1'b1, 1'b0, 1'b0, 2'd2, 16'h0);
        check(st8 == 8'h00, "R9 mode change keeps state", {8'h0, st8}, 16'h0);
        step(1'b1, 1'b0, 1'b1, 2'd2, 16'h0);
        check(st8 == 8'h01, "R8 lfsr leaves zero", {8'h0, st8}, 16'h1);
        step(1'b1, 1'b1, 1'b0, 2'd1, 16'h0);
        step(1'b1, 1'b0, 1'b1, 2'd0, 16'h0);
        check(st8 == 8'h01 && st3 == 3'h1, "R8 ring leaves zero", {8'h0, st8}, 16'h1);
        step(1'b1, 1'b1, 1'b0, 2'd0, 16'h0081);
        step(1'b1, 1'b0, 1'b1, 2'd1, 16'h0);
        check(st8 == 8'h02, "R9 twist feedback after switch", {8'h0, st8}, 16'h2);

        // Random mix of all controls
        for (int i = 0; i < 3000; i++) begin
            logic rn;
            logic ld;
            logic en;
            rn = ($urandom % 64) != 0;
            ld = ($urandom % 16) == 0;
            en = ($urandom % 4) != 0;
            step(rn, ld, en, 2'($urandom % 4), 16'($urandom));
        end

        finish_run();
    end

endmodule